// File: doc/BRIEF.md
# Board Interrupt Aggregator with Identification Registers

This block gathers a group of external interrupt sources into one sticky status word. It raises a single active-low, level-sensitive interrupt line towards a host processor while any unmasked status bit is set. Each source input passes through a synchroniser. A rising edge on the synchronised input sets that source's status bit, and the bit holds until the host clears it.

The host reaches the block over a simple synchronous 16-bit register bus with a word address, a read strobe, a write strobe and write data. Three fixed signature words and a revision word let boot software confirm that the board is fitted before it touches anything else. To clear a status bit, software writes a 1 to that bit of the clear register and then writes 0 to release it. While a clear bit is held at 1, its status bit stays at 0.

Word addresses: 0, 1 and 2 are the signature words, 3 is the revision, 4 is status (read-only), 5 is the mask, 6 is the clear register, and 7 is unmapped.

Top module: `dbg_irq_hub`

## Requirements
- R1: Reads of addresses 0, 1 and 2 return 0xAAAA, 0x5555 and 0xCAFE respectively, and writes to those addresses change nothing.
- R2: A read of address 3 returns the VERSION parameter (default 0x0107), and writes to it change nothing.
- R3: After reset the mask reads 0xFFFF, status reads 0x0000, the clear register reads 0x0000, irq_n is 1 and bus_rdata is 0.
- R4: A 0-to-1 transition on src_in[i], after synchronisation, sets status bit i (status is address 4, bit i = source i). The bit stays set after the source returns to 0.
- R5: irq_n is 0 exactly when some status bit is set whose mask bit is 0. A mask bit of 1 disables its source, and the output follows as a level.
- R6: Writing 1 to bit i of the clear register (address 6) clears status bit i. While that bit is held at 1, new edges on source i leave status bit i at 0. After 0 is written back, new edges set it again.
- R7: Writes to the status address and to address 7 change no register, and a read of address 7 returns 0.
- R8: The mask (address 5) and the clear register read back the last value written to them.
- R9: Read data appears on bus_rdata in the cycle after the read strobe and is 0 in every cycle that follows no read.
- R10: A source held high across a clear-and-release does not set its status bit again; only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (3) | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_in | input | NUM_SRC (16) | Asynchronous interrupt source inputs |
| irq_n | output | 1 | Active-low level interrupt to the host |

## Verification
The bench pulses sources while their clear bits are held. A design that lets an edge through under a held clear would show a status bit set after release without any new edge. It holds a source high across a clear-and-release. A design that reacts to level rather than to edges would set the bit again at once. It writes to the status, signature and unmapped addresses. A decoder that aliases those writes would alter the mask or the clear register, which shows up when those registers are read back. Random mixes of mask and pending patterns check that irq_n is low exactly when some unmasked bit is set. A polarity or masking slip would assert the line for masked sources, or leave it high with one pending.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;
  localparam int WORD_W = 16;
  localparam int OFF_SIG0 = 0;
  localparam int OFF_SIG1 = 1;
  localparam int OFF_SIG2 = 2;
  localparam int OFF_VER  = 3;
  localparam int OFF_STAT = 4;
  localparam int OFF_MASK = 5;
  localparam int OFF_CLR  = 6;
  localparam logic [WORD_W-1:0] SIG_WORD0 = 16'hAAAA;
  localparam logic [WORD_W-1:0] SIG_WORD1 = 16'h5555;
  localparam logic [WORD_W-1:0] SIG_WORD2 = 16'hCAFE;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int NUM_SRC = 16,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_SRC-1:0] rise
);
  // Each lane: STAGES synchroniser flops followed by one history flop.
  localparam int CHAIN = STAGES + 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[CHAIN-2:0], src_in[g]};
    end
    assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] rise,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] status_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         status_q[g] <= 1'b0;
      else if (clr[g]) status_q[g] <= 1'b0;
      else if (rise[g]) status_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import dbg_irq_pkg::*;
#(
  parameter int               NUM_SRC = 16,
  parameter int               AW      = 3,
  parameter logic [WORD_W-1:0] VERSION = 16'h0107
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [WORD_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] clr_q,
  output logic [WORD_W-1:0]  bus_rdata
);
  logic hit_mask, hit_clr;
  logic [WORD_W-1:0] rd_val;

  assign hit_mask = (bus_addr == AW'(OFF_MASK));
  assign hit_clr  = (bus_addr == AW'(OFF_CLR));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      clr_q  <= '0;
    end else if (bus_wr) begin
      if (hit_mask) mask_q <= bus_wdata[NUM_SRC-1:0];
      if (hit_clr)  clr_q  <= bus_wdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      AW'(OFF_SIG0): rd_val = SIG_WORD0;
      AW'(OFF_SIG1): rd_val = SIG_WORD1;
      AW'(OFF_SIG2): rd_val = SIG_WORD2;
      AW'(OFF_VER):  rd_val = VERSION;
      AW'(OFF_STAT): rd_val[NUM_SRC-1:0] = status;
      AW'(OFF_MASK): rd_val[NUM_SRC-1:0] = mask_q;
      AW'(OFF_CLR):  rd_val[NUM_SRC-1:0] = clr_q;
      default:       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/dbg_irq_hub.sv
module dbg_irq_hub
  import dbg_irq_pkg::*;
#(
  parameter int               NUM_SRC     = 16,
  parameter int               AW          = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] VERSION    = 16'h0107
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_n
);
  logic [NUM_SRC-1:0] rise_w, status_w, mask_w, clr_w;

  irq_src_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .src_in(src_in), .rise(rise_w)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk(clk), .rst(rst), .rise(rise_w), .clr(clr_w), .status_q(status_w)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .AW(AW), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .status(status_w),
    .mask_q(mask_w), .clr_q(clr_w), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(status_w & ~mask_w);
  end
endmodule

// File: rtl/dbg_irq_hub_chk.sv
module dbg_irq_hub_chk #(
  parameter int NUM_SRC = 16,
  parameter int AW      = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [15:0]        bus_wdata,
  input logic [15:0]        bus_rdata,
  input logic               irq_n,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] clr_q
);
  AST_SIG0_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(0)) |=> (bus_rdata == 16'hAAAA)); // R1

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == ~|($past(status_q) & ~$past(mask_q)))); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((($past(status_q) & ~status_q) & ~$past(clr_q)) == '0)); // R4

  AST_CLR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((status_q & $past(clr_q)) == '0)); // R6

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(5)) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0]))); // R8

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == 16'h0000)); // R9
endmodule

bind dbg_irq_hub dbg_irq_hub_chk #(.NUM_SRC(NUM_SRC), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_n(irq_n), .status_q(status_w), .mask_q(mask_w), .clr_q(clr_w)
);

// File: tb/test_dbg_irq_hub.sv
`timescale 1ns/1ps
module test_dbg_irq_hub;
  localparam int NS = 16;
  localparam logic [15:0] VER = 16'h0107;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NS-1:0] src_in = '0;
  logic irq_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_stat, m_mask, m_clr;

  always #4 clk = ~clk;

  dbg_irq_hub #(.NUM_SRC(NS), .VERSION(VER)) i_dbg_irq_hub (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_n(irq_n)
  );

  function automatic logic exp_irq_n(logic [15:0] st, logic [15:0] mk);
    return ~|(st & ~mk);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [15:0] bits);
    @(negedge clk); src_in = src_in | bits;
    idle(4);
    src_in = src_in & ~bits;
    idle(4);
    m_stat = m_stat | (bits & ~m_clr);
  endtask

  task automatic check_all(string tag);
    logic [15:0] v;
    idle(2);
    rd(3'd4, v); check({tag, " R4 status"}, v, m_stat);
    rd(3'd5, v); check({tag, " R8 mask"}, v, m_mask);
    rd(3'd6, v); check({tag, " R8 clear"}, v, m_clr);
    check({tag, " R5 irq_n"}, {15'd0, irq_n}, {15'd0, exp_irq_n(m_stat, m_mask)});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unused;
    unused = $urandom(32'h5EED_0A11);
    m_stat = '0; m_mask = 16'hFFFF; m_clr = '0;
    idle(4);
    @(negedge clk); rst = 1'b0;

    // R3 reset state
    check("R3 irq_n after reset", {15'd0, irq_n}, 16'h0001);
    check("R3 rdata after reset", bus_rdata, 16'h0000);
    rd(3'd5, v); check("R3 mask reset", v, 16'hFFFF);
    rd(3'd4, v); check("R3 status reset", v, 16'h0000);
    rd(3'd6, v); check("R3 clear reset", v, 16'h0000);

    // R1, R2 signatures and version, R7 unmapped
    rd(3'd0, v); check("R1 sig0", v, 16'hAAAA);
    rd(3'd1, v); check("R1 sig1", v, 16'h5555);
    rd(3'd2, v); check("R1 sig2", v, 16'hCAFE);
    rd(3'd3, v); check("R2 version", v, VER);
    rd(3'd7, v); check("R7 unmapped read", v, 16'h0000);

    // R9 read data returns to zero after the strobe
    @(negedge clk); check("R9 rdata idle", bus_rdata, 16'h0000);

    // R1 R2 R7 writes to read-only/unmapped are ignored
    wr(3'd0, 16'h1234); wr(3'd3, 16'h4321); wr(3'd4, 16'hFFFF); wr(3'd7, 16'h00FF);
    rd(3'd0, v); check("R1 sig0 after write", v, 16'hAAAA);
    rd(3'd3, v); check("R2 version after write", v, VER);
    check_all("R7 after stray writes");

    // R4 masked source pending but irq stays high
    pulse(16'h0001);
    check_all("R4 masked pulse");
    wr(3'd5, 16'hFFE0); m_mask = 16'hFFE0;
    check_all("R5 unmask low five");
    wr(3'd5, 16'hFFFF); m_mask = 16'hFFFF;
    check_all("R5 remask all");

    // R6 clear then hold clear while source toggles
    wr(3'd6, 16'h0001); m_clr = 16'h0001; m_stat = m_stat & ~16'h0001;
    pulse(16'h0001);
    check_all("R6 edge under held clear");
    wr(3'd6, 16'h0000); m_clr = 16'h0000;
    check_all("R6 release");
    pulse(16'h0001);
    check_all("R6 edge after release");

    // R10 level held across clear-and-release
    @(negedge clk); src_in[3] = 1'b1; idle(5);
    m_stat = m_stat | 16'h0008;
    wr(3'd6, 16'hFFFF); m_clr = 16'hFFFF; m_stat = '0;
    wr(3'd6, 16'h0000); m_clr = 16'h0000;
    idle(5);
    check_all("R10 held level no reset");
    @(negedge clk); src_in[3] = 1'b0; idle(4);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      int op;
      logic [15:0] r;
      op = int'($urandom_range(0, 3));
      r = 16'($urandom);
      case (op)
        0: pulse(r & 16'($urandom));
        1: begin wr(3'd5, r); m_mask = r; end
        2: begin
             wr(3'd6, r); m_clr = r; m_stat = m_stat & ~r;
             pulse(16'($urandom));
             wr(3'd6, 16'h0000); m_clr = 16'h0000;
           end
        default: begin
             wr(3'd7, r); wr(3'd4, r);
             rd(3'd2, v); check("R1 random sig2", v, 16'hCAFE);
           end
      endcase
      check_all("random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule